// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit host bus reach a slow, byte-wide register file that lives in a separate subsystem. The host never addresses the inner registers directly. It programs a control word with an 8-bit inner address, a direction and byte-lane enables. For a write it then supplies the data word. The bridge runs one request/acknowledge transfer on the inner bus, and for a read it returns the result in the lower data word.

While a transfer is outstanding, a read-only busy bit in the control word stays high. Software polls it before the next access. The bridge also turns the subsystem's interrupt line, and its own transfer-complete event, into sticky flags. Software clears each flag by writing a one to it. A per-bit enable register masks the flags onto one host interrupt output.

Host accesses are single-cycle. Writes take effect on the clock edge that samples `hostWr`. Reads are combinational from `hostAddr`.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, busy (control bit 31) is 0 and `innReq` and `hostIrq` are 0. The control, lower data, upper data, enable and flag words all read 0. The ID word at offset 0x00 reads the parameter `ID_VALUE`.
- R2: The control word at offset 0x04 stores the inner address in bits 7:0, the lower-lane byte enables in bits 19:16, the upper-lane byte enables in bits 23:20 and the direction in bit 24, where 1 means read. Bits 15:8 and 30:25 read 0. Bit 31 is busy and cannot be written.
- R3: A host write to the lower data word at offset 0x08, made while idle with direction 0, stores the word and starts a write transfer. From the next cycle, `innReq`=1 and `innWr`=1. At the same time `innAddr` shows control bits 7:0, `innWdata` shows lower data bits 7:0 and `innLaneEn` shows control bits 23:16.
- R4: A host write to the control word while idle with bit 24 set starts a read transfer. From the next cycle, `innReq`=1 and `innWr`=0, and `innAddr` shows the new address.
- R5: Busy reads 1 from the cycle after a transfer starts. `innReq` stays high until the edge that samples `innAck`=1, and drops on that edge. Busy clears on the following edge.
- R6: In a read transfer, the `innRdata` value sampled with the acknowledge appears in lower data bits 7:0, with bits 31:8 zero, on the edge where busy clears. Until that edge the lower data word keeps its old value.
- R7: Host writes to the control, lower data and upper data words (offset 0x0C for upper) are ignored while busy. Reads of these words return the last stored values.
- R8: A rising edge on `subIrq` sets flag bit 1 at offset 0x14, whatever the enable setting. A level held high does not set the bit again after it has been cleared.
- R9: Flag bit 0 sets on the edge where a transfer completes (busy clears).
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event and a clear fall on the same edge, the set wins.
- R11: `hostIrq` is high exactly when some flag bit is high and its enable bit at offset 0x10 (bit 1 subsystem, bit 0 interface) is also high. The enable bits read back in bits 1:0.
- R12: The upper data word stores any 32-bit value written while idle and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostAddr | input | 5 | Host byte offset (word aligned) |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for `hostAddr` |
| hostIrq | output | 1 | Masked OR of the interrupt flags |
| innReq | output | 1 | Inner transfer request |
| innWr | output | 1 | Inner transfer direction, 1 = write |
| innAddr | output | 8 | Inner register address |
| innWdata | output | 8 | Inner write byte |
| innLaneEn | output | 8 | Byte-lane enables from the control word |
| innRdata | input | 8 | Inner read byte, valid with `innAck` |
| innAck | input | 1 | Inner transfer acknowledge |
| subIrq | input | 1 | Subsystem interrupt line |

## Verification
The hardest situation to reach from the ports is a set event and a write-one clear landing on the same edge. The stimulus raises `subIrq` on the same negative edge that drives the clear write, so both arrive together at the next rising edge.

The other hard window is the single cycle between the acknowledge and busy clearing. The bench holds `innAck` for exactly one cycle and reads the lower data word and busy inside that window. Host writes are also placed while the request is held open, to show they are dropped.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int HOST_AW = 5;
  localparam int WORD_W  = 32;

  localparam logic [2:0] IDX_ID   = 3'd0;
  localparam logic [2:0] IDX_CTL  = 3'd1;
  localparam logic [2:0] IDX_LOW  = 3'd2;
  localparam logic [2:0] IDX_UP   = 3'd3;
  localparam logic [2:0] IDX_EN   = 3'd4;
  localparam logic [2:0] IDX_FLG  = 3'd5;

  localparam int BIT_BUSY = 31;
  localparam int BIT_DIR  = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_FIN} xfer_state_t;

  typedef struct packed {
    logic loadCtl;
    logic loadLow;
    logic loadUp;
    logic loadEn;
    logic clrFlag;
    logic captureRd;
    logic commitRd;
    logic xferDone;
  } strobe_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               wrDirBit,
  input  logic               ctlDir,
  input  logic               innAck,
  output strobe_t            stb,
  output logic               busy,
  output logic               innReq,
  output logic               innWr
);
  xfer_state_t state, stateNxt;
  logic opRead;
  logic idle;
  logic [2:0] idx;
  logic startRd, startWr;

  assign idx  = hostAddr[HOST_AW-1:2];
  assign idle = (state == ST_IDLE);

  always_comb begin
    stb = '0;
    stb.loadCtl   = hostWr && (idx == IDX_CTL) && idle;
    stb.loadLow   = hostWr && (idx == IDX_LOW) && idle;
    stb.loadUp    = hostWr && (idx == IDX_UP)  && idle;
    stb.loadEn    = hostWr && (idx == IDX_EN);
    stb.clrFlag   = hostWr && (idx == IDX_FLG);
    stb.captureRd = (state == ST_REQ) && innAck && opRead;
    stb.commitRd  = (state == ST_FIN) && opRead;
    stb.xferDone  = (state == ST_FIN);
  end

  assign startRd = stb.loadCtl && wrDirBit;
  assign startWr = stb.loadLow && !ctlDir;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (startRd || startWr) stateNxt = ST_REQ;
      ST_REQ:  if (innAck) stateNxt = ST_FIN;
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opRead <= 1'b0;
    end else begin
      state <= stateNxt;
      if (idle && (startRd || startWr)) opRead <= startRd;
    end
  end

  assign busy   = !idle;
  assign innReq = (state == ST_REQ);
  assign innWr  = !opRead;
endmodule

// File: rtl/bridge_dpath.sv
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int INN_AW = 8,
  parameter int INN_DW = 8,
  parameter int LANE_W = 8,
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h0001_0A00
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               busy,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0]  hostWdata,
  input  logic [INN_DW-1:0]  innRdata,
  input  logic               subIrq,
  output logic [WORD_W-1:0]  hostRdata,
  output logic               ctlDir,
  output logic [INN_AW-1:0]  innAddr,
  output logic [INN_DW-1:0]  innWdata,
  output logic [LANE_W-1:0]  innLaneEn,
  output logic [1:0]         intEn,
  output logic [1:0]         intFlag
);
  logic [INN_AW-1:0] ctlAddr;
  logic [LANE_W-1:0] ctlLane;
  logic [WORD_W-1:0] lowData, upData;
  logic [INN_DW-1:0] capData;
  logic              subIrqQ;
  logic [1:0]        setEvt;
  logic [WORD_W-1:0] ctlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlAddr <= '0;
      ctlLane <= '0;
      ctlDir  <= 1'b0;
      lowData <= '0;
      upData  <= '0;
      capData <= '0;
      intEn   <= '0;
    end else begin
      if (stb.loadCtl) begin
        ctlAddr <= hostWdata[INN_AW-1:0];
        ctlLane <= hostWdata[16 +: LANE_W];
        ctlDir  <= hostWdata[BIT_DIR];
      end
      if (stb.captureRd) capData <= innRdata;
      if (stb.commitRd)     lowData <= {{(WORD_W-INN_DW){1'b0}}, capData};
      else if (stb.loadLow) lowData <= hostWdata;
      if (stb.loadUp) upData <= hostWdata;
      if (stb.loadEn) intEn <= hostWdata[1:0];
    end
  end

  // Interrupt flags: bit 1 from subsystem edge, bit 0 from transfer completion.
  assign setEvt = {subIrq && !subIrqQ, stb.xferDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subIrqQ <= 1'b0;
      intFlag <= '0;
    end else begin
      subIrqQ <= subIrq;
      for (int i = 0; i < 2; i++) begin
        if (setEvt[i])                           intFlag[i] <= 1'b1;
        else if (stb.clrFlag && hostWdata[i])    intFlag[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctlWord = '0;
    ctlWord[BIT_BUSY]      = busy;
    ctlWord[BIT_DIR]       = ctlDir;
    ctlWord[16 +: LANE_W]  = ctlLane;
    ctlWord[INN_AW-1:0]    = ctlAddr;
  end

  always_comb begin
    case (hostAddr[HOST_AW-1:2])
      IDX_ID:  hostRdata = ID_VALUE;
      IDX_CTL: hostRdata = ctlWord;
      IDX_LOW: hostRdata = lowData;
      IDX_UP:  hostRdata = upData;
      IDX_EN:  hostRdata = {{(WORD_W-2){1'b0}}, intEn};
      IDX_FLG: hostRdata = {{(WORD_W-2){1'b0}}, intFlag};
      default: hostRdata = '0;
    endcase
  end

  assign innAddr   = ctlAddr;
  assign innWdata  = lowData[INN_DW-1:0];
  assign innLaneEn = ctlLane;
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import bridge_pkg::*;
#(
  parameter int INN_AW = 8,
  parameter int INN_DW = 8,
  parameter int LANE_W = 8,
  parameter logic [31:0] ID_VALUE = 32'h0001_0A00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [4:0]        hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostIrq,
  output logic              innReq,
  output logic              innWr,
  output logic [INN_AW-1:0] innAddr,
  output logic [INN_DW-1:0] innWdata,
  output logic [LANE_W-1:0] innLaneEn,
  input  logic [INN_DW-1:0] innRdata,
  input  logic              innAck,
  input  logic              subIrq
);
  strobe_t    stb;
  logic       busy;
  logic       ctlDir;
  logic [1:0] intEn, intFlag;

  bridge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .wrDirBit (hostWdata[BIT_DIR]),
    .ctlDir   (ctlDir),
    .innAck   (innAck),
    .stb      (stb),
    .busy     (busy),
    .innReq   (innReq),
    .innWr    (innWr)
  );

  bridge_dpath #(
    .INN_AW   (INN_AW),
    .INN_DW   (INN_DW),
    .LANE_W   (LANE_W),
    .ID_VALUE (ID_VALUE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .innRdata  (innRdata),
    .subIrq    (subIrq),
    .hostRdata (hostRdata),
    .ctlDir    (ctlDir),
    .innAddr   (innAddr),
    .innWdata  (innWdata),
    .innLaneEn (innLaneEn),
    .intEn     (intEn),
    .intFlag   (intFlag)
  );

  assign hostIrq = |(intFlag & intEn);
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk (
  input logic       clk,
  input logic       rstN,
  input logic       innReq,
  input logic       innAck,
  input logic       busy,
  input logic       hostIrq,
  input logic       subIrq,
  input logic [1:0] intEn,
  input logic [1:0] intFlag
);
  // R5
  req_drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    innReq && innAck |=> !innReq && busy);

  // R5
  fin_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !innReq |=> !busy);

  // R5
  req_implies_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    innReq |-> busy);

  // R8
  sub_edge_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(subIrq) |=> intFlag[1]);

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == 2'b00) |-> !hostIrq);
endmodule

bind ireg_bridge ireg_bridge_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .innReq  (innReq),
  .innAck  (innAck),
  .busy    (busy),
  .hostIrq (hostIrq),
  .subIrq  (subIrq),
  .intEn   (intEn),
  .intFlag (intFlag)
);

// File: tb/ireg_bridge_tb_top.sv
module ireg_bridge_tb_top;
  localparam logic [31:0] IDV = 32'h0001_0A00;
  localparam logic [4:0] A_ID = 5'h00, A_CTL = 5'h04, A_LOW = 5'h08,
                         A_UP = 5'h0C, A_EN = 5'h10, A_FLG = 5'h14;

  typedef struct packed {
    logic        isWr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_ID,  IDV,          8'd1},   // R1 id
    '{1'b0, A_CTL, 32'h0,        8'd1},   // R1 control reset
    '{1'b0, A_LOW, 32'h0,        8'd1},   // R1 lower reset
    '{1'b0, A_FLG, 32'h0,        8'd1},   // R1 flag reset
    '{1'b0, A_EN,  32'h0,        8'd1},   // R1 enable reset
    '{1'b1, A_CTL, 32'h40F3_AB5A, 8'd2},  // R2 write, dir 0
    '{1'b0, A_CTL, 32'h00F3_005A, 8'd2},  // R2 readback
    '{1'b1, A_UP,  32'hDEAD_BEEF, 8'd12},
    '{1'b0, A_UP,  32'hDEAD_BEEF, 8'd12}, // R12
    '{1'b1, A_EN,  32'hFFFF_FFFF, 8'd11},
    '{1'b0, A_EN,  32'h3,        8'd11},  // R11
    '{1'b1, A_EN,  32'h0,        8'd11}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWr = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic hostIrq, innReq, innWr, innAck = 1'b0, subIrq = 1'b0;
  logic [7:0] innAddr, innWdata, innLaneEn, innRdata = '0;
  int nChk = 0, nErr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ireg_bridge dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .innReq(innReq), .innWr(innWr), .innAddr(innAddr), .innWdata(innWdata),
    .innLaneEn(innLaneEn), .innRdata(innRdata), .innAck(innAck), .subIrq(subIrq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hread(input logic [4:0] a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdata;
  endtask

  task automatic ackOnce(input logic [7:0] rd);
    innAck = 1'b1; innRdata = rd;
    @(negedge clk);
    innAck = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 innReq", {31'b0, innReq}, 32'h0);
    check("R1 hostIrq", {31'b0, hostIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) hwrite(VEC[i].addr, VEC[i].data);
      else begin
        hread(VEC[i].addr, v);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].data);
      end
    end

    // R3: write transfer
    hwrite(A_CTL, 32'h0001_0042);
    hwrite(A_LOW, 32'h1234_56A5);   // now one cycle after the start edge
    check("R3 innReq", {31'b0, innReq}, 32'h1);
    check("R3 innWr", {31'b0, innWr}, 32'h1);
    check("R3 fields", {8'h0, innAddr, innWdata, innLaneEn}, 32'h0042_A501);
    hread(A_CTL, v);
    check("R5 busy set", {31'b0, v[31]}, 32'h1);
    // R7: writes while busy are ignored
    hwrite(A_CTL, 32'h01FF_0077);
    hwrite(A_UP, 32'h5555_5555);
    hwrite(A_LOW, 32'h0000_0000);
    check("R5 req held", {31'b0, innReq}, 32'h1);
    hread(A_CTL, v);  check("R7 ctl held", v, 32'h8001_0042);
    hread(A_UP, v);   check("R7 up held", v, 32'hDEAD_BEEF);
    hread(A_LOW, v);  check("R7 low held", v, 32'h1234_56A5);
    ackOnce(8'h00);
    check("R5 req drop", {31'b0, innReq}, 32'h0);
    hread(A_CTL, v);  check("R5 busy fin", {31'b0, v[31]}, 32'h1);
    @(negedge clk);
    hread(A_CTL, v);  check("R5 busy clear", {31'b0, v[31]}, 32'h0);
    hread(A_FLG, v);  check("R9 done flag", v, 32'h1);

    // R4 / R6: read transfer
    hwrite(A_CTL, 32'h0101_0033);
    check("R4 innReq", {31'b0, innReq}, 32'h1);
    check("R4 innWr", {31'b0, innWr}, 32'h0);
    check("R4 addr", {24'b0, innAddr}, 32'h33);
    @(negedge clk);
    ackOnce(8'h5C);
    hread(A_LOW, v);  check("R6 not yet", v, 32'h1234_56A5);
    @(negedge clk);
    hread(A_LOW, v);  check("R6 data", v, 32'h0000_005C);
    hread(A_CTL, v);  check("R6 idle", {31'b0, v[31]}, 32'h0);

    // R10 / R11 interface flag
    hwrite(A_FLG, 32'h0);
    hread(A_FLG, v);  check("R10 write0 keeps", v, 32'h1);
    hwrite(A_EN, 32'h1);
    check("R11 irq on", {31'b0, hostIrq}, 32'h1);
    hwrite(A_FLG, 32'h1);
    hread(A_FLG, v);  check("R10 w1c", v, 32'h0);
    check("R11 irq off", {31'b0, hostIrq}, 32'h0);

    // R8 subsystem edge
    hwrite(A_EN, 32'h0);
    subIrq = 1'b1;
    @(negedge clk); @(negedge clk);
    hread(A_FLG, v);  check("R8 set", v, 32'h2);
    check("R11 masked", {31'b0, hostIrq}, 32'h0);
    hwrite(A_EN, 32'h2);
    check("R11 enabled", {31'b0, hostIrq}, 32'h1);
    hwrite(A_FLG, 32'h2);
    @(negedge clk);
    hread(A_FLG, v);  check("R8 level no reset", v, 32'h0);
    subIrq = 1'b0;
    @(negedge clk);
    // R10: set wins over same-edge clear
    hostWr = 1'b1; hostAddr = A_FLG; hostWdata = 32'h2; subIrq = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    hread(A_FLG, v);  check("R10 set wins", v, 32'h2);

    // R1: reset again restores
    rstN = 1'b0;
    @(negedge clk);
    hread(A_FLG, v);  check("R1 reset flag", v, 32'h0);
    hread(A_UP, v);   check("R1 reset up", v, 32'h0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        nChk++; nErr++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule